// File: doc/BRIEF.md
# Pixel Clock Program Word Calculator

This block turns a requested pixel clock frequency, given in units of 0.01 MHz, into the 13-bit program word that a serially loaded frequency synthesizer expects. It also reports the post-divider it chose and flags requests it cannot serve. A request is accepted with a one-cycle `start` strobe while the block is idle. The result appears together with a one-cycle `done` pulse.

The calculation runs in three phases. First the request is range-checked. Then it is doubled, one doubling per cycle, until it reaches the VCO band at 8000, and each doubling doubles the post-divider. Finally the folded frequency is multiplied by 46000 and passed twice through one shared restoring divider, first by 1432 and then by 1000 after 500 is added for rounding. The result, less 257, is packed with a post-divider code and two fixed high bits.

Top module: `pclk_word_calc`

## Requirements
- R1: After reset, `done`, `busy` and `err` are 0, and `prog_word` and `post_div` are 0.
- R2: A request above 15938 gives `done` together with `err`=1, `prog_word`=0 and `post_div`=0, one clock edge after the edge that samples `start`.
- R3: A request below 1000 is rejected in the same way as in R2: `err`=1, zero outputs, and `done` one edge after `start`. A request of exactly 1000 is accepted.
- R4: For an accepted request f, `post_div` is the smallest of 1, 2, 4 or 8 for which f×`post_div` ≥ 8000. The folded frequency fs is f×`post_div`. `post_div` is coded as a plain binary value.
- R5: `prog_word[8:0]` = floor((floor(46000×fs/1432)+500)/1000) − 257. This field can reach 257, which sets bit 8 (for example, f=7999 gives 0x101).
- R6: `prog_word[10:9]` is 3 for divide-by-1, 2 for divide-by-2, 1 for divide-by-4 and 0 for divide-by-8.
- R7: `prog_word[12:11]` is 2'b11 in every accepted result.
- R8: `loc_addr` is always 0.
- R9: A `start` that arrives while `busy` is 1 is ignored. The result and its timing belong to the first request, and exactly one `done` pulse follows.
- R10: `done` is a single-cycle pulse. For an accepted request with k doublings, it rises 62+k edges after the edge that samples `start`: one cycle to accept, k+1 cycles for folding, and 30 cycles for each of the two divisions. `busy` is 1 from the accept edge until `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled while idle |
| freq_in | input | 16 | Requested frequency in 0.01 MHz |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | Request out of range |
| prog_word | output | 13 | Synthesizer program word |
| post_div | output | 4 | Chosen post-divider (1, 2, 4 or 8) |
| loc_addr | output | 5 | Synthesizer location address, constant 0 |

## Verification
Requests already inside the band (8000, 10000, 15938) exercise the divider and the rounding with no folding. Requests of 7999, 4000, 2520 and 1000 need one, one, two and three doublings, so they separate each post-divider code and each latency. The value 7999 also drives the count field to 257, and 1000 and 8000 mark the lower edges. Values just past each limit (999, 15939), together with 0 and 65535, exercise the rejection path. A sweep compared against an arithmetic model, and a second `start` sent mid-computation, cover the remaining rounding cases and R9.

// File: rtl/pclk_word_calc.sv
module pclk_word_calc #(
  parameter int FW       = 16,
  parameter int F_MAX    = 15938,
  parameter int F_MIN    = 1000,
  parameter int BAND_LO  = 8000,
  parameter int REF_DIV  = 46,
  parameter int REF_FREQ = 1432,
  parameter int SCALE    = 1000,
  parameter int N_ADJ    = 257
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] freq_in,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [12:0]   prog_word,
  output logic [3:0]    post_div,
  output logic [4:0]    loc_addr
);

  localparam int  MULK  = REF_DIV * SCALE;
  localparam int  DW    = $clog2((2 * BAND_LO - 1) * MULK + 1);
  localparam int  DMAX  = (REF_FREQ > SCALE) ? REF_FREQ : SCALE;
  localparam int  RW    = $clog2(DMAX + 1) + 1;
  localparam int  CW    = $clog2(DW);
  localparam int  RND   = SCALE / 2;
  localparam logic [1:0] STOP = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_FOLD, S_DIV} st_t;

  st_t            state;
  logic [FW-1:0]  fr;
  logic [3:0]     pd;
  logic           ph;
  logic [CW-1:0]  cnt;
  logic [DW-1:0]  dvd, quo;
  logic [RW-1:0]  rem, dsr;

  logic [RW-1:0]  trial;
  logic           ge;
  logic [DW-1:0]  quo_n;
  logic [DW-1:0]  adj;
  logic           bad;
  logic           last;
  logic [1:0]     code;

  assign loc_addr = '0;
  assign busy     = (state != S_IDLE);
  assign bad      = (freq_in > FW'(F_MAX)) || (freq_in < FW'(F_MIN));

  assign trial = {rem[RW-2:0], dvd[DW-1]};
  assign ge    = (trial >= dsr);
  assign quo_n = {quo[DW-2:0], ge};
  assign adj   = quo_n - DW'(N_ADJ);
  assign last  = (state == S_DIV) && ph && (cnt == CW'(DW - 1));

  always_comb begin
    case (pd)
      4'd1:    code = 2'd3;
      4'd2:    code = 2'd2;
      4'd4:    code = 2'd1;
      default: code = 2'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      fr        <= '0;
      pd        <= '0;
      ph        <= 1'b0;
      cnt       <= '0;
      dvd       <= '0;
      quo       <= '0;
      rem       <= '0;
      dsr       <= '0;
      done      <= 1'b0;
      err       <= 1'b0;
      prog_word <= '0;
      post_div  <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            if (bad) begin
              done      <= 1'b1;
              err       <= 1'b1;
              prog_word <= '0;
              post_div  <= '0;
            end else begin
              fr    <= freq_in;
              pd    <= 4'd1;
              state <= S_FOLD;
            end
          end
        end
        S_FOLD: begin
          if (fr < FW'(BAND_LO)) begin
            fr <= fr << 1;
            pd <= pd << 1;
          end else begin
            dvd   <= DW'(fr) * DW'(MULK);
            dsr   <= RW'(REF_FREQ);
            quo   <= '0;
            rem   <= '0;
            cnt   <= '0;
            ph    <= 1'b0;
            state <= S_DIV;
          end
        end
        S_DIV: begin
          if (cnt == CW'(DW - 1)) begin
            if (!ph) begin
              dvd <= quo_n + DW'(RND);
              dsr <= RW'(SCALE);
              quo <= '0;
              rem <= '0;
              cnt <= '0;
              ph  <= 1'b1;
            end else begin
              prog_word <= {STOP, code, adj[8:0]};
              post_div  <= pd;
              err       <= 1'b0;
              done      <= 1'b1;
              state     <= S_IDLE;
            end
          end else begin
            dvd <= dvd << 1;
            quo <= quo_n;
            rem <= ge ? (trial - dsr) : trial;
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_high_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && freq_in > FW'(F_MAX)) |=> (done && err && prog_word == '0));

  a_r3_low_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && freq_in < FW'(F_MIN)) |=> (done && err && post_div == '0));

  a_r4_band_reached: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DIV) |-> (fr >= FW'(BAND_LO) && fr < FW'(2 * BAND_LO)));

  a_r6_single_divider: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> ($countones(post_div) == 1));

  a_r7_stop_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (prog_word[12:11] == 2'b11));

  a_r9_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (done && !err && !busy));

endmodule

// File: tb/pclk_word_calc_tb.sv
module pclk_word_calc_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] freq_in = '0;
  logic        busy, done, err;
  logic [12:0] prog_word;
  logic [3:0]  post_div;
  logic [4:0]  loc_addr;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  pclk_word_calc u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .freq_in(freq_in),
    .busy(busy), .done(done), .err(err), .prog_word(prog_word),
    .post_div(post_div), .loc_addr(loc_addr)
  );

  localparam int NV = 11;
  localparam logic [15:0] VF [NV] = '{16'd8000, 16'd15938, 16'd10000, 16'd7999, 16'd4000,
                                      16'd2520, 16'd1000, 16'd15939, 16'd999, 16'd0, 16'd65535};
  localparam logic [12:0] VW [NV] = '{13'h1E00, 13'h1EFF, 13'h1E40, 13'h1D01, 13'h1C00,
                                      13'h1A43, 13'h1800, 13'h0, 13'h0, 13'h0, 13'h0};
  localparam logic [3:0]  VP [NV] = '{4'd1, 4'd1, 4'd1, 4'd2, 4'd2, 4'd4, 4'd8, 4'd0, 4'd0, 4'd0, 4'd0};
  localparam logic        VE [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int lat_of(input logic [3:0] pd, input logic e);
    if (e) return 1;
    case (pd)
      4'd1: return 62;
      4'd2: return 63;
      4'd4: return 64;
      default: return 65;
    endcase
  endfunction

  task automatic model(input int f, output logic [12:0] w, output logic [3:0] pd, output logic e);
    longint fs, t, c;
    logic [1:0] cd;
    if (f > 15938 || f < 1000) begin
      w = '0; pd = '0; e = 1'b1;
    end else begin
      fs = f; pd = 4'd1; e = 1'b0;
      while (fs < 8000) begin fs = fs * 2; pd = pd << 1; end
      t = (46000 * fs) / 1432;
      c = (t + 500) / 1000 - 257;
      cd = (pd == 4'd1) ? 2'd3 : (pd == 4'd2) ? 2'd2 : (pd == 4'd4) ? 2'd1 : 2'd0;
      w = {2'b11, cd, 9'(c)};
    end
  endtask

  task automatic run(input logic [15:0] f, output logic [12:0] w, output logic [3:0] pd,
                     output logic e, output int lat);
    start = 1'b1; freq_in = f;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 500) begin @(negedge clk); lat++; end
    w = prog_word; pd = post_div; e = err;
    if (lat >= 500) check("R10 timeout", 0, 1);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [12:0] w, ew;
    logic [3:0]  pd, ep;
    logic        e, ee;
    int          lat;
    int          extra;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 done", done, 0);
    check("R1 busy", busy, 0);
    check("R1 err", err, 0);
    check("R1 prog_word", prog_word, 0);
    check("R1 post_div", post_div, 0);
    check("R8 loc_addr", loc_addr, 0);

    for (int i = 0; i < NV; i++) begin
      run(VF[i], w, pd, e, lat);
      if (VE[i]) begin
        check("R2/R3 err", e, 1);
        check("R2/R3 zero word", w, 0);
        check("R2/R3 zero post_div", pd, 0);
      end else begin
        check("R4 post_div", pd, VP[i]);
        check("R5 count field", w[8:0], VW[i][8:0]);
        check("R6 code field", w[10:9], VW[i][10:9]);
        check("R7 stop field", w[12:11], 2'b11);
        check("R2/R3 err clear", e, 0);
      end
      check("R10 latency", lat, lat_of(VP[i], VE[i]));
      check("R8 loc_addr", loc_addr, 0);
    end

    // R5 sweep against arithmetic model
    for (int f = 1000; f <= 15938; f += 1237) begin
      model(f, ew, ep, ee);
      run(16'(f), w, pd, e, lat);
      check("R5 sweep word", w, ew);
      check("R4 sweep post_div", pd, ep);
    end

    // R9 second start while busy is ignored
    start = 1'b1; freq_in = 16'd10000;
    @(negedge clk);
    start = 1'b0;
    repeat (9) @(negedge clk);
    check("R10 busy mid-run", busy, 1);
    start = 1'b1; freq_in = 16'd2520;
    @(negedge clk);
    start = 1'b0; freq_in = 16'd0;
    lat = 11;
    while (!done && lat < 500) begin @(negedge clk); lat++; end
    check("R9 latency of first request", lat, 62);
    check("R9 word of first request", prog_word, 13'h1E40);
    check("R9 post_div of first request", post_div, 1);
    @(negedge clk);
    check("R10 done single pulse", done, 0);
    check("R10 busy after done", busy, 0);
    extra = 0;
    for (int c = 0; c < 80; c++) begin
      if (done) extra++;
      @(negedge clk);
    end
    check("R9 no second done", extra, 0);

    // R3 boundary: error then valid back to back
    run(16'd999, w, pd, e, lat);
    check("R3 999 rejected", e, 1);
    run(16'd1000, w, pd, e, lat);
    check("R3 1000 accepted", e, 0);
    check("R3 1000 word", w, 13'h1800);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule